// File: doc/BRIEF.md
# Supply Fault Supervisor and Restart Sequencer

This block decides when two PWM channels may switch. The first is an auxiliary channel that produces the bootstrap supply. The second is the main channel, which depends on that bootstrap supply. The block watches a set of already-synchronized single-bit status flags. Comparators elsewhere produce these flags, so the block never handles an analog threshold. From them it produces a run level for each channel. The auxiliary channel is released first. The main channel follows once the bootstrap rail has climbed above the main supply.

Any input-level fault drops both run levels at once:
- reference not good,
- input undervoltage,
- input overvoltage,
- enable inactive.

Such a fault is not latched. Once the fault is gone, switching resumes only after the bootstrap rail has been seen below its reset level.

A digital timer replaces the external timing capacitor. It counts while either output-undervoltage flag is high. When the count reaches a programmable terminal value, the timer latches a timeout. The timeout holds both channels off until a deliberate clear sequence is applied.

Top module: `supply_seq_supervisor`

## Requirements
- R1: During and immediately after reset, run_aux, run_main, fault and timeout_latched are all 0. The power-up start needs no low-bootstrap indication.
- R2: run_aux goes to 1 one clock after a cycle in which all of the following hold: vcc_on=1, ref_ok=1, no input fault, no timeout, and restart permitted.
- R3: run_main goes to 1 one clock after a cycle in which run_aux was already 1 and boot_above=1. It then stays 1 for as long as run_aux stays 1, and it is never 1 while run_aux is 0.
- R4: The enable is active when en_pol=1 and en_in=0, or when en_pol=0 and en_in=1. Any other combination is an enable fault.
- R5: Any of the following drives run_aux and run_main to 0 on the next clock: ref_ok=0, in_uv=1, in_ov=1, or an inactive enable. The fault output shows this fault condition one clock late.
- R6: After a fault is removed, both run outputs stay 0 until boot_low=1 is sampled in a cycle with no fault present.
- R7: Consider a run of consecutive cycles in which ouv_aux or ouv_main is 1. timeout_latched goes to 1 one clock after the term_count-th cycle of that run, and a term_count of 0 acts as 1. Both run outputs go to 0 on that same clock.
- R8: Any cycle with both ouv flags at 0 before the timeout sets the count back to zero, so a later run of flagged cycles counts from the beginning again.
- R9: A latched timeout clears on the clock after a cycle that meets all three conditions:
  - both ouv flags are 0,
  - boot_low=1,
  - en_in or in_uv differs from its value in the previous cycle.
  Toggles made without all three conditions leave the timeout set.
- R10: After a timeout clear or a fault restart, start-up repeats the same order: restart is permitted, then run_aux is released, then run_main is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 1 | Internal reference within tolerance |
| vcc_on | input | 1 | Main supply above its turn-on level |
| boot_above | input | 1 | Bootstrap supply above main supply |
| boot_low | input | 1 | Bootstrap supply below its reset level |
| in_uv | input | 1 | Input undervoltage flag |
| in_ov | input | 1 | Input overvoltage flag |
| en_in | input | 1 | Enable input |
| en_pol | input | 1 | Enable polarity: 1 means active-low enable |
| ouv_aux | input | 1 | Auxiliary output undervoltage flag |
| ouv_main | input | 1 | Main output undervoltage flag |
| term_count | input | CNT_W | Timer terminal count |
| run_aux | output | 1 | Auxiliary channel run |
| run_main | output | 1 | Main channel run |
| fault | output | 1 | Registered non-latched fault status |
| timeout_latched | output | 1 | Latched output-undervoltage timeout |

## Verification
The bench builds the block with CNT_W=4. This makes it practical to sweep every terminal count from 0 to 15, including the zero case and the largest value the counter can hold.

With all five fault-related inputs swept through their 32 combinations, every pairing of enable polarity and level is covered, and so is every mix of simultaneous faults. Each combination is followed by a restart that must wait for the low-bootstrap flag.

The short counter also lets each timeout be followed by a series of clear attempts. Some of these attempts are invalid and must be ignored. The sequence ends with a valid one, after which the staged start-up must repeat.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned SEQ_DEFAULT_CNT_W = 16;

  // Enable is active when its level opposes the polarity select.
  function automatic logic en_active(input logic en, input logic pol);
    return pol ? ~en : en;
  endfunction
endpackage

// File: rtl/seq_fault_gate.sv
module seq_fault_gate
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ok,
  input  logic in_uv,
  input  logic in_ov,
  input  logic en_in,
  input  logic en_pol,
  output logic fault_now,
  output logic toggle_seen
);
  logic en_d, uv_d;

  always_comb begin
    fault_now   = ~ref_ok | in_uv | in_ov | ~en_active(en_in, en_pol);
    toggle_seen = (en_in ^ en_d) | (in_uv ^ uv_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d <= 1'b0;
      uv_d <= 1'b0;
    end else begin
      en_d <= en_in;
      uv_d <= in_uv;
    end
  end
endmodule

// File: rtl/seq_ouv_timer.sv
module seq_ouv_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ouv_any,
  input  logic [CNT_W-1:0] term,
  input  logic             clear_req,
  output logic             to_q,
  output logic             to_set
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;
  logic             do_clear;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + EXT_W'(1);
    to_set   = ~to_q & ouv_any & (cnt_inc >= {1'b0, term});
    do_clear = to_q & ~ouv_any & clear_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (to_q) begin
      if (do_clear) begin
        cnt_q <= '0;
        to_q  <= 1'b0;
      end
    end else if (ouv_any) begin
      if (to_set) to_q  <= 1'b1;
      else        cnt_q <= cnt_inc[CNT_W-1:0];
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_now,
  input  logic to_q,
  input  logic to_set,
  input  logic vcc_on,
  input  logic boot_low,
  input  logic boot_above,
  output logic run_aux,
  output logic run_main
);
  logic armed_q, armed_nxt, aux_nxt, main_nxt;

  always_comb begin
    armed_nxt = (fault_now | to_q) ? 1'b0 : (armed_q | boot_low);
    aux_nxt   = armed_nxt & vcc_on & ~to_q & ~to_set;
    main_nxt  = aux_nxt & (run_main | (run_aux & boot_above));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b1;
      run_aux  <= 1'b0;
      run_main <= 1'b0;
    end else begin
      armed_q  <= armed_nxt;
      run_aux  <= aux_nxt;
      run_main <= main_nxt;
    end
  end
endmodule

// File: rtl/supply_seq_supervisor.sv
module supply_seq_supervisor #(
  parameter int unsigned CNT_W = seq_pkg::SEQ_DEFAULT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ok,
  input  logic             vcc_on,
  input  logic             boot_above,
  input  logic             boot_low,
  input  logic             in_uv,
  input  logic             in_ov,
  input  logic             en_in,
  input  logic             en_pol,
  input  logic             ouv_aux,
  input  logic             ouv_main,
  input  logic [CNT_W-1:0] term_count,
  output logic             run_aux,
  output logic             run_main,
  output logic             fault,
  output logic             timeout_latched
);
  logic fault_now, toggle_seen, to_set, to_q;

  seq_fault_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .in_uv(in_uv), .in_ov(in_ov),
    .en_in(en_in), .en_pol(en_pol), .fault_now(fault_now), .toggle_seen(toggle_seen)
  );

  seq_ouv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ouv_any(ouv_aux | ouv_main), .term(term_count),
    .clear_req(toggle_seen & boot_low), .to_q(to_q), .to_set(to_set)
  );

  seq_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .fault_now(fault_now), .to_q(to_q), .to_set(to_set),
    .vcc_on(vcc_on), .boot_low(boot_low), .boot_above(boot_above),
    .run_aux(run_aux), .run_main(run_main)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= fault_now;
  end

  assign timeout_latched = to_q;
endmodule

// File: rtl/supply_seq_checker.sv
module supply_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_ok,
  input logic vcc_on,
  input logic boot_above,
  input logic boot_low,
  input logic in_uv,
  input logic in_ov,
  input logic ouv_aux,
  input logic ouv_main,
  input logic run_aux,
  input logic run_main,
  input logic timeout_latched
);
  a_r3_main_needs_aux: assert property (@(posedge clk) disable iff (!rst_n)
    run_main |-> run_aux);

  a_r3_main_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_main) |-> ($past(run_aux) && $past(boot_above)));

  a_r2_aux_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_aux) |-> ($past(vcc_on) && $past(ref_ok)));

  a_r5_fault_drops_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ok || in_uv || in_ov) |=> (!run_aux && !run_main));

  a_r7_timeout_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_latched |-> (!run_aux && !run_main));

  a_r9_clear_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_latched) |-> ($past(boot_low) && !$past(ouv_aux) && !$past(ouv_main)));
endmodule

bind supply_seq_supervisor supply_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .vcc_on(vcc_on),
  .boot_above(boot_above), .boot_low(boot_low), .in_uv(in_uv), .in_ov(in_ov),
  .ouv_aux(ouv_aux), .ouv_main(ouv_main), .run_aux(run_aux),
  .run_main(run_main), .timeout_latched(timeout_latched)
);

// File: tb/tb_supply_seq_supervisor.sv
module tb_supply_seq_supervisor;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ok = 1'b1, vcc_on = 1'b1, boot_above = 1'b1, boot_low = 1'b0;
  logic in_uv = 1'b0, in_ov = 1'b0, en_in = 1'b0, en_pol = 1'b1;
  logic ouv_aux = 1'b0, ouv_main = 1'b0;
  logic [CW-1:0] term_count = 4'd3;
  logic run_aux, run_main, fault, timeout_latched;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state
  bit m_armed, m_aux, m_main, m_fault, m_to, p_en, p_uv;
  int m_cnt;

  always #4 clk = ~clk;

  supply_seq_supervisor #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .vcc_on(vcc_on),
    .boot_above(boot_above), .boot_low(boot_low), .in_uv(in_uv), .in_ov(in_ov),
    .en_in(en_in), .en_pol(en_pol), .ouv_aux(ouv_aux), .ouv_main(ouv_main),
    .term_count(term_count), .run_aux(run_aux), .run_main(run_main),
    .fault(fault), .timeout_latched(timeout_latched)
  );

  task automatic compare(input string tag);
    logic [3:0] act, exp;
    act = {run_aux, run_main, fault, timeout_latched};
    exp = {m_aux, m_main, m_fault, m_to};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t {aux,main,fault,timeout} actual=%b expected=%b",
               tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_armed = 1'b1; m_aux = 1'b0; m_main = 1'b0; m_fault = 1'b0;
    m_to = 1'b0; p_en = 1'b0; p_uv = 1'b0; m_cnt = 0;
  endtask

  task automatic step(input string tag);
    bit en_ok, flt, flag, tog, to_set, clr, n_armed, n_aux, n_main, n_to;
    int n_cnt, tc;
    tc     = (int'(term_count) == 0) ? 1 : int'(term_count);
    en_ok  = en_pol ? !en_in : en_in;                       // R4
    flt    = !ref_ok || in_uv || in_ov || !en_ok;          // R5
    flag   = ouv_aux || ouv_main;
    tog    = (en_in != p_en) || (in_uv != p_uv);
    to_set = !m_to && flag && (m_cnt + 1 >= tc);           // R7
    clr    = m_to && !flag && boot_low && tog;             // R9
    n_to   = m_to ? !clr : to_set;
    if (m_to)      n_cnt = clr ? 0 : m_cnt;
    else if (flag) n_cnt = to_set ? m_cnt : m_cnt + 1;
    else           n_cnt = 0;                              // R8
    n_armed = (flt || m_to) ? 1'b0 : (m_armed || boot_low); // R6
    n_aux   = n_armed && vcc_on && !m_to && !to_set;        // R2
    n_main  = n_aux && (m_main || (m_aux && boot_above));   // R3
    @(posedge clk);
    @(negedge clk);
    m_armed = n_armed; m_aux = n_aux; m_main = n_main; m_fault = flt;
    m_to = n_to; m_cnt = n_cnt; p_en = en_in; p_uv = in_uv;
    compare(tag);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    vcc_on = 1'b0;
    boot_above = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step("R1");
    steps(3, "R2");            // vcc_on low keeps aux off
    vcc_on = 1'b1;
    steps(2, "R2");
    steps(3, "R3");            // boot_above low keeps main off
    boot_above = 1'b1;
    steps(3, "R3");

    // Sweep all fault-input combinations, then a restart for each
    for (int i = 0; i < 32; i++) begin
      ref_ok = i[0];
      in_uv  = i[1];
      in_ov  = i[2];
      en_in  = i[3];
      en_pol = i[4];
      steps(2, "R5");
      step("R4");
      ref_ok = 1'b1; in_uv = 1'b0; in_ov = 1'b0; en_in = !en_pol;
      steps(3, "R6");
      boot_low = 1'b1;
      step("R6");
      boot_low = 1'b0;
      steps(3, "R10");
    end

    // Timer sweep over every terminal count
    for (int tc = 0; tc < 16; tc++) begin
      term_count = CW'(tc);
      if (tc % 2 == 0) ouv_aux = 1'b1; else ouv_main = 1'b1;
      steps(tc + 2, "R7");
      ouv_aux = 1'b0; ouv_main = 1'b0;
      step("R7");
      en_in = !en_in;                       // toggle without boot_low
      step("R9");
      en_in = !en_in;
      step("R9");
      boot_low = 1'b1;
      boot_above = !boot_above;              // unrelated toggle
      step("R9");
      boot_above = 1'b1;
      ouv_main = 1'b1; in_uv = 1'b1;        // toggle while flag high
      step("R9");
      ouv_main = 1'b0; in_uv = 1'b0;        // valid toggle
      step("R9");
      steps(2, "R9");
      boot_low = 1'b0;
      steps(4, "R10");
    end

    // Interrupted counting restarts from zero
    term_count = 4'd5;
    ouv_aux = 1'b1;
    steps(4, "R8");
    ouv_aux = 1'b0;
    step("R8");
    ouv_main = 1'b1;
    steps(4, "R8");
    step("R8");
    ouv_main = 1'b0;
    steps(2, "R8");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule